// File: doc/BRIEF.md
# Indirect Switch Register Access Sequencer

This block lets a host reach the internal registers of a switch that answers on only one management address. Each host request names a target device, a register and, for writes, 16 bits of data. When the configured switch address is non-zero, the sequencer does not access the target directly. It packs the request into a command word, writes that word into register 0 of the switch address, and watches a busy flag in the same register before and after the command. A read then takes its result from register 1. A write first puts its data into register 1.

When the configured switch address is zero, the switch answers on every address. The sequencer then makes one direct access to the requested device and register.

The downstream side is an abstract register-level management port with a request/acknowledge handshake. Serial bit timing on that port is handled elsewhere.

Top module: `mgmt_indirect_seq`

## Requirements
- R1: With `sw_addr` equal to zero, an accepted request makes exactly one port access. That access goes to `req_dev`/`req_reg`, uses the request's direction and data, and returns its result and error flag.
- R2: With a non-zero `sw_addr`, the block first reads register 0 at `sw_addr` until bit 15 reads 0. It stops with `done_err` and `done_tmo` both set once RETRY_MAX (default 16) consecutive polls have seen bit 15 set. With 15 busy polls followed by a clear one, the access goes ahead.
- R3: An indirect read writes `0x9800 | dev<<5 | reg` to register 0 and waits for the busy flag to clear. It then reads register 1 and returns that value on `rdata`. The device field sits in bits 9:5 and the register field in bits 4:0.
- R4: An indirect write puts `req_wdata` into register 1 first. It then writes `0x9400 | dev<<5 | reg` to register 0 and waits for the busy flag to clear.
- R5: A port access acknowledged with `mp_err` ends the sequence on the next cycle, with `done_err` set and `done_tmo` clear. No further port access follows.
- R6: `req_ready` is high only while no request is in progress. Request inputs presented while a request is in progress have no effect.
- R7: `done` is a one-cycle pulse. `done_tmo` is never set without `done_err`.
- R8: The poll counter restarts at each wait phase. A wait after the command gets the full retry budget, whatever the wait before the command used.
- R9: After reset, `req_ready` is high and `done` and `mp_req` are low.
- R10: While `mp_req` is high and not yet acknowledged, the direction, address, register and data of the port access stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_addr | input | 5 | Switch management address; zero selects direct access |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Target device address |
| req_reg | input | 5 | Target register number |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion carried an error (valid with `done`) |
| done_tmo | output | 1 | Error was a busy-poll timeout (valid with `done`) |
| rdata | output | 16 | Read result (valid with `done` on a successful read) |
| mp_req | output | 1 | Port access request, held until acknowledged |
| mp_write | output | 1 | Port access direction |
| mp_phy | output | 5 | Port access address |
| mp_reg | output | 5 | Port access register |
| mp_wdata | output | 16 | Port write data |
| mp_ack | input | 1 | Port access completed |
| mp_err | input | 1 | Port access failed (with `mp_ack`) |
| mp_rdata | input | 16 | Port read data (with `mp_ack`) |

## Verification
The bench sets up 15 busy polls and then a clear one, to catch an off-by-one in the retry limit that would wrongly time out. It also sets up 16 busy polls, where a design that lets a 17th poll through would report success instead of a timeout. Running both waits at 15 exposes a counter that is not reset between phases, because the second wait would then time out. Errors are injected at the data write, at the poll after the command and at the final data fetch. A design that keeps going after an error shows up through an extra access count. Requests that stay on the inputs during a busy sequence must leave the model's register contents untouched.

// File: rtl/mgmt_indirect_seq.sv
module mgmt_indirect_seq #(
  parameter int RETRY_MAX = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  sw_addr,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [4:0]  req_dev,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        done,
  output logic        done_err,
  output logic        done_tmo,
  output logic [15:0] rdata,
  output logic        mp_req,
  output logic        mp_write,
  output logic [4:0]  mp_phy,
  output logic [4:0]  mp_reg,
  output logic [15:0] mp_wdata,
  input  logic        mp_ack,
  input  logic        mp_err,
  input  logic [15:0] mp_rdata
);
  localparam int CW = $clog2(RETRY_MAX + 1);
  localparam logic [15:0] OP_RD = 16'h9800;
  localparam logic [15:0] OP_WR = 16'h9400;
  localparam int BUSY_BIT = 15;

  typedef enum logic [2:0] {
    S_IDLE, S_DIRECT, S_WAIT_PRE, S_DATA, S_CMD, S_WAIT_POST, S_FETCH
  } st_t;

  st_t         st, st_n;
  logic        wr_q;
  logic [4:0]  dev_q, reg_q, sw_q;
  logic [15:0] wd_q;
  logic [CW-1:0] cnt, cnt_n;
  logic        fin, fin_err, fin_tmo, take_rd;
  logic [15:0] cmd_word;

  assign req_ready = (st == S_IDLE);
  assign mp_req    = (st != S_IDLE);
  assign cmd_word  = (wr_q ? OP_WR : OP_RD) | {6'b0, dev_q, reg_q};

  always_comb begin
    mp_write = 1'b0;
    mp_phy   = sw_q;
    mp_reg   = 5'd0;
    mp_wdata = 16'h0000;
    case (st)
      S_DIRECT: begin
        mp_write = wr_q;
        mp_phy   = dev_q;
        mp_reg   = reg_q;
        mp_wdata = wd_q;
      end
      S_DATA: begin
        mp_write = 1'b1;
        mp_reg   = 5'd1;
        mp_wdata = wd_q;
      end
      S_CMD: begin
        mp_write = 1'b1;
        mp_wdata = cmd_word;
      end
      S_FETCH: mp_reg = 5'd1;
      default: ;
    endcase
  end

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    fin     = 1'b0;
    fin_err = 1'b0;
    fin_tmo = 1'b0;
    take_rd = 1'b0;
    if (st == S_IDLE) begin
      if (req_valid) begin
        st_n  = (sw_addr == 5'd0) ? S_DIRECT : S_WAIT_PRE;
        cnt_n = '0;
      end
    end else if (mp_ack) begin
      if (mp_err) begin
        fin     = 1'b1;
        fin_err = 1'b1;
      end else begin
        case (st)
          S_DIRECT: begin
            fin     = 1'b1;
            take_rd = !wr_q;
          end
          S_WAIT_PRE, S_WAIT_POST: begin
            if (mp_rdata[BUSY_BIT]) begin
              if (cnt == CW'(RETRY_MAX - 1)) begin
                fin     = 1'b1;
                fin_err = 1'b1;
                fin_tmo = 1'b1;
              end else begin
                cnt_n = cnt + 1'b1;
              end
            end else begin
              cnt_n = '0;
              if (st == S_WAIT_PRE) st_n = wr_q ? S_DATA : S_CMD;
              else if (wr_q)        fin  = 1'b1;
              else                  st_n = S_FETCH;
            end
          end
          S_DATA: st_n = S_CMD;
          S_CMD: begin
            st_n  = S_WAIT_POST;
            cnt_n = '0;
          end
          S_FETCH: begin
            fin     = 1'b1;
            take_rd = 1'b1;
          end
          default: st_n = S_IDLE;
        endcase
      end
    end
    if (fin) st_n = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      dev_q    <= 5'd0;
      reg_q    <= 5'd0;
      sw_q     <= 5'd0;
      wd_q     <= 16'h0000;
      done     <= 1'b0;
      done_err <= 1'b0;
      done_tmo <= 1'b0;
      rdata    <= 16'h0000;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      done <= fin;
      if (st == S_IDLE && req_valid) begin
        wr_q  <= req_write;
        dev_q <= req_dev;
        reg_q <= req_reg;
        wd_q  <= req_wdata;
        sw_q  <= sw_addr;
      end
      if (fin) begin
        done_err <= fin_err;
        done_tmo <= fin_tmo;
      end
      if (take_rd) rdata <= mp_rdata;
    end
  end
endmodule

// File: rtl/mgmt_indirect_seq_chk.sv
module mgmt_indirect_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        done,
  input logic        done_err,
  input logic        done_tmo,
  input logic        mp_req,
  input logic        mp_write,
  input logic [4:0]  mp_phy,
  input logic [4:0]  mp_reg,
  input logic [15:0] mp_wdata,
  input logic        mp_ack,
  input logic        mp_err
);
  // R6
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mp_req |-> !req_ready);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  tmo_has_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_tmo) |-> done_err);

  // R5
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_req && mp_ack && mp_err) |=> (done && done_err && !done_tmo && !mp_req));

  // R10
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_req && !mp_ack) |=> (mp_req && $stable({mp_write, mp_phy, mp_reg, mp_wdata})));
endmodule

bind mgmt_indirect_seq mgmt_indirect_seq_chk u_chk (.*);

// File: tb/mgmt_indirect_seq_bench.sv
`timescale 1ns/1ps
module mgmt_indirect_seq_bench;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [4:0]  sw_addr = 0;
  logic        req_valid = 0, req_write = 0;
  logic [4:0]  req_dev = 0, req_reg = 0;
  logic [15:0] req_wdata = 0;
  logic        req_ready, done, done_err, done_tmo;
  logic [15:0] rdata;
  logic        mp_req, mp_write;
  logic [4:0]  mp_phy, mp_reg;
  logic [15:0] mp_wdata;
  logic        mp_ack, mp_err;
  logic [15:0] mp_rdata;

  mgmt_indirect_seq u_mgmt_indirect_seq (.*);

  // switch and register-space model
  logic [15:0] mem [32][32];
  logic [15:0] shadow, last_cmd;
  logic [5:0]  cfg_pre = 0, cfg_post = 0, polls;
  logic [7:0]  cfg_erat = 0, txn;
  logic        phase, arm = 0;

  function automatic logic [15:0] f(input logic [4:0] d, input logic [4:0] r);
    return (16'(d) * 16'h0811) ^ (16'(r) * 16'h1021) ^ 16'h5A00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 32; d++)
        for (int r = 0; r < 32; r++) mem[d][r] <= f(5'(d), 5'(r));
      mp_ack <= 0; mp_err <= 0; mp_rdata <= 0; txn <= 0;
      phase <= 0; polls <= 0; shadow <= 0; last_cmd <= 0;
    end else if (arm) begin
      mp_ack <= 0; txn <= 0; phase <= 0; polls <= 0; last_cmd <= 0;
    end else if (mp_ack) begin
      mp_ack <= 0;
    end else if (mp_req) begin
      mp_ack <= 1; txn <= txn + 1; mp_err <= 0; mp_rdata <= 0;
      if (txn + 8'd1 == cfg_erat) mp_err <= 1;
      else if (sw_addr != 0 && mp_phy == sw_addr) begin
        if (mp_reg == 0) begin
          if (mp_write) begin
            last_cmd <= mp_wdata; phase <= 1; polls <= 0;
            if (mp_wdata[10]) mem[mp_wdata[9:5]][mp_wdata[4:0]] <= shadow;
            else shadow <= mem[mp_wdata[9:5]][mp_wdata[4:0]];
          end else begin
            mp_rdata <= {((phase == 0) ? (polls < cfg_pre) : (polls < cfg_post)), 15'h0};
            polls <= polls + 1;
          end
        end else if (mp_reg == 1) begin
          if (mp_write) shadow <= mp_wdata;
          else mp_rdata <= shadow;
        end
      end else begin
        if (mp_write) mem[mp_phy][mp_reg] <= mp_wdata;
        else mp_rdata <= mem[mp_phy][mp_reg];
      end
    end
  end

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic [4:0] sw; logic wr; logic [4:0] dev; logic [4:0] rg; logic [15:0] wd;
    logic [5:0] pre; logic [5:0] post; logic [7:0] erat;
    logic xerr; logic xtmo; logic [7:0] xtxn;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{5'd0,  1'b0, 5'd3,  5'd7,  16'h0000, 6'd0,  6'd0,  8'd0, 1'b0, 1'b0, 8'd1},   // R1 direct read
    '{5'd0,  1'b1, 5'd9,  5'd2,  16'hBEEF, 6'd0,  6'd0,  8'd0, 1'b0, 1'b0, 8'd1},   // R1 direct write
    '{5'd16, 1'b0, 5'd4,  5'd1,  16'h0000, 6'd0,  6'd0,  8'd0, 1'b0, 1'b0, 8'd4},   // R3 read
    '{5'd16, 1'b1, 5'd17, 5'd30, 16'h1234, 6'd2,  6'd3,  8'd0, 1'b0, 1'b0, 8'd9},   // R4 write
    '{5'd31, 1'b0, 5'd31, 5'd31, 16'h0000, 6'd15, 6'd15, 8'd0, 1'b0, 1'b0, 8'd34},  // R2 R8 limit
    '{5'd16, 1'b0, 5'd4,  5'd5,  16'h0000, 6'd16, 6'd0,  8'd0, 1'b1, 1'b1, 8'd16},  // R2 timeout pre
    '{5'd16, 1'b1, 5'd6,  5'd6,  16'h7777, 6'd0,  6'd16, 8'd0, 1'b1, 1'b1, 8'd19},  // R2 timeout post
    '{5'd16, 1'b0, 5'd6,  5'd8,  16'h0000, 6'd0,  6'd16, 8'd0, 1'b1, 1'b1, 8'd18},  // R2 timeout post rd
    '{5'd16, 1'b1, 5'd7,  5'd7,  16'h4444, 6'd0,  6'd0,  8'd2, 1'b1, 1'b0, 8'd2},   // R5 data write err
    '{5'd16, 1'b0, 5'd8,  5'd8,  16'h0000, 6'd0,  6'd0,  8'd3, 1'b1, 1'b0, 8'd3},   // R5 post poll err
    '{5'd0,  1'b0, 5'd1,  5'd1,  16'h0000, 6'd0,  6'd0,  8'd1, 1'b1, 1'b0, 8'd1},   // R5 direct err
    '{5'd16, 1'b0, 5'd9,  5'd9,  16'h0000, 6'd1,  6'd1,  8'd6, 1'b1, 1'b0, 8'd6}    // R5 fetch err
  };

  task automatic wait_done(output bit seen);
    int n = 0;
    seen = 0;
    while (n < 400) begin
      if (done) begin seen = 1; break; end
      @(negedge clk); n++;
    end
  endtask

  initial begin
    bit seen;
    int busy_ready;
    repeat (3) @(negedge clk);
    // R9
    chk("R9 ready", req_ready === 1'b1, 32'(req_ready), 1);
    chk("R9 done", done === 1'b0, 32'(done), 0);
    chk("R9 mp_req", mp_req === 1'b0, 32'(mp_req), 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      sw_addr = v.sw; cfg_pre = v.pre; cfg_post = v.post; cfg_erat = v.erat;
      arm = 1; @(negedge clk); arm = 0;
      req_write = v.wr; req_dev = v.dev; req_reg = v.rg; req_wdata = v.wd; req_valid = 1;
      while (!req_ready) @(negedge clk);
      @(negedge clk); req_valid = 0;
      wait_done(seen);
      chk($sformatf("R7 done seen v%0d", i), seen, 32'(seen), 1);
      chk($sformatf("R5 R2 err v%0d", i), done_err === v.xerr, 32'(done_err), 32'(v.xerr));
      chk($sformatf("R2 tmo v%0d", i), done_tmo === v.xtmo, 32'(done_tmo), 32'(v.xtmo));
      chk($sformatf("R1 R5 access count v%0d", i), txn === v.xtxn, 32'(txn), 32'(v.xtxn));
      if (!v.xerr && !v.wr)
        chk($sformatf("R3 R1 rdata v%0d", i), rdata === f(v.dev, v.rg), 32'(rdata), 32'(f(v.dev, v.rg)));
      if (!v.xerr && v.wr)
        chk($sformatf("R4 R1 stored v%0d", i), mem[v.dev][v.rg] === v.wd, 32'(mem[v.dev][v.rg]), 32'(v.wd));
      if (!v.xerr && v.sw != 0) begin
        logic [15:0] ec = (v.wr ? 16'h9400 : 16'h9800) | {6'b0, v.dev, v.rg};
        chk($sformatf("R3 R4 command v%0d", i), last_cmd === ec, 32'(last_cmd), 32'(ec));
      end
      @(negedge clk);
      chk($sformatf("R7 pulse v%0d", i), done === 1'b0, 32'(done), 0);
    end

    // R6: inputs held during a busy sequence are ignored
    sw_addr = 5'd16; cfg_pre = 3; cfg_post = 3; cfg_erat = 0;
    arm = 1; @(negedge clk); arm = 0;
    req_write = 0; req_dev = 2; req_reg = 3; req_valid = 1;
    @(negedge clk);
    req_write = 1; req_dev = 5; req_reg = 5; req_wdata = 16'hAAAA;
    busy_ready = 0; seen = 0;
    for (int n = 0; n < 400; n++) begin
      if (done) begin seen = 1; req_valid = 0; break; end
      if (req_ready) busy_ready++;
      @(negedge clk);
    end
    chk("R6 done", seen, 32'(seen), 1);
    chk("R6 ready low while busy", busy_ready == 0, 32'(busy_ready), 0);
    chk("R6 rdata of first request", rdata === f(5'd2, 5'd3), 32'(rdata), 32'(f(5'd2, 5'd3)));
    chk("R6 access count", txn === 8'd10, 32'(txn), 10);
    chk("R6 held write ignored", mem[5][5] === f(5'd5, 5'd5), 32'(mem[5][5]), 32'(f(5'd5, 5'd5)));
    repeat (3) @(negedge clk);
    chk("R6 no second start", mp_req === 1'b0, 32'(mp_req), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule